// File: doc/BRIEF.md
# Stand-Alone Converter Control Sequencer

This block is the digital control side of a 12-bit successive-approximation converter used without a host handshake. One strobe input carries both roles: a high level asks for the result, and a falling edge starts a new conversion. A status output is high while a conversion runs. The result is presented on a 12-bit data port with a separate output-enable, which a pad ring turns into a tri-state bus. The analog front end is not modelled. The value that the conversion would produce is taken from a test input at the moment the conversion ends.

Every delay is given in nanoseconds and converted to clock cycles from a clock-period parameter. At the default 20 ns period the delays are as follows. Status rises 30 cycles after the start edge is sampled. The result is captured 1750 cycles after that edge. Status falls 15 cycles after the capture.

A width select picks between two ways of presenting the result. The first shows all 12 bits at once. The second is a left-justified byte mode for narrow buses, in which an address bit chooses which byte is shown. Strobe edges that arrive during a conversion are ignored and flagged.

Top module: `adc_sa_ctrl`

## Requirements
- R1: A falling strobe edge sampled while idle starts a conversion. Status rises 30 cycles after the edge that samples the strobe low.
- R2: Once status is high, it stays high without a gap until the conversion and its hold time are over.
- R3: The result input is captured 1750 cycles after the start edge, so a value applied before that point is the one reported. Status falls 15 cycles after the capture.
- R4: The data outputs are enabled only while the strobe is high and a completed result is held, one cycle after the strobe is sampled. While the enable is low, the data port reads zero. A strobe held low through a conversion keeps the outputs disabled until the strobe rises.
- R5: With the width select at 1, data bits 11..0 carry the full result.
- R6: With the width select at 0 and the address at 0, data bits 7..0 carry result bits 11..4 and bits 11..8 are zero. The port follows a change of select one cycle later.
- R7: With the width select at 0 and the address at 1, data bits 7..4 carry result bits 3..0 and bits 11..8 and 3..0 are zero.
- R8: A falling strobe edge during a conversion or its hold time does not change the timing or the result. It raises the overrun output for exactly one cycle, starting on the cycle after the edge.
- R9: After reset, status, overrun, output enable and data are all zero.
- R10: No output is enabled before the first result exists. A new start edge disables the outputs on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_i | input | 1 | Read/convert strobe: high reads, falling edge starts |
| wide_i | input | 1 | 1 = full-width output, 0 = byte mode |
| addr_i | input | 1 | Byte select in byte mode (0 upper, 1 lower) |
| result_i | input | 12 | Stand-in for the analog conversion value |
| busy_o | output | 1 | Conversion status |
| data_o | output | 12 | Formatted result, zero while not enabled |
| data_oe_o | output | 1 | Drive enable for the data pads |
| overrun_o | output | 1 | One-cycle flag for an ignored start edge |

## Verification
Each result is due at a fixed cycle after the edge that samples the start. Status rises after 30 edges, the output enable returns 1751 edges after the start, and status falls after 1765 edges. Format and enable changes appear one edge after their inputs move, and the overrun flag appears one edge after the stray fall. The bench drives inputs on falling clock edges and counts falling edges from each stimulus. Each value is checked both one count before its due edge and at it, so an early or late change is caught. The result input changes part-way through each conversion, which shows that capture happens at the end and not at the start.

// File: rtl/adc_sa_pkg.sv
package adc_sa_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CONV = 2'd1,
    SQ_HOLD = 2'd2
  } seq_state_t;

  // Round a delay in ns up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sa_edge_det.sv
module sa_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic rc_i,
  output logic fall_o
);
  logic rc_q;

  // Strobe idles high, so the history register resets high.
  always_ff @(posedge clk) begin
    if (rst) rc_q <= 1'b1;
    else     rc_q <= rc_i;
  end

  assign fall_o = rc_q & ~rc_i;
endmodule

// File: rtl/sa_conv_seq.sv
module sa_conv_seq
  import adc_sa_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int STS_CYC  = 30,
  parameter int CONV_CYC = 1750,
  parameter int HOLD_CYC = 15,
  parameter int CNT_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_i,
  input  logic [RES_W-1:0] result_i,
  output logic             busy_o,
  output logic             ovr_o,
  output logic             valid_o,
  output logic [RES_W-1:0] res_o
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      busy_o  <= 1'b0;
      ovr_o   <= 1'b0;
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      ovr_o <= fall_i && (state != SQ_IDLE);
      unique case (state)
        SQ_IDLE: begin
          if (fall_i) begin
            state   <= SQ_CONV;
            cnt     <= CNT_W'(1);
            valid_o <= 1'b0;
          end
        end
        SQ_CONV: begin
          if (cnt == CNT_W'(STS_CYC)) busy_o <= 1'b1;
          if (cnt == CNT_W'(CONV_CYC)) begin
            res_o   <= result_i;
            valid_o <= 1'b1;
            state   <= SQ_HOLD;
            cnt     <= CNT_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        SQ_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYC)) begin
            busy_o <= 1'b0;
            state  <= SQ_IDLE;
            cnt    <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R1: status may only rise inside a running conversion
  p_busy_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (state == SQ_CONV));

  // R2: status covers the whole hold window
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_HOLD) |-> busy_o);

  // R3: status drops only once a result is held and the sequencer is idle
  p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (state == SQ_IDLE) && valid_o);

  // R8: the overrun flag comes only from an edge seen while not idle
  p_ovr_src_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> ($past(state) != SQ_IDLE) && $past(fall_i));

  // R8: the flag is a single-cycle pulse when the strobe goes back high
  p_ovr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_o && !fall_i |=> !ovr_o);
endmodule

// File: rtl/sa_out_fmt.sv
module sa_out_fmt #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rc_i,
  input  logic             wide_i,
  input  logic             addr_i,
  input  logic             valid_i,
  input  logic [RES_W-1:0] res_i,
  output logic             oe_o,
  output logic [RES_W-1:0] data_o
);
  localparam int LO_SH = 2 * BYTE_W - RES_W;

  logic [RES_W-1:0] lo_sh;
  logic [RES_W-1:0] sel;
  logic             drive;

  assign lo_sh = res_i << LO_SH;
  assign drive = rc_i & valid_i;

  always_comb begin
    if (wide_i)       sel = res_i;
    else if (!addr_i) sel = RES_W'(res_i[RES_W-1 -: BYTE_W]);
    else              sel = RES_W'(lo_sh[BYTE_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o   <= 1'b0;
      data_o <= '0;
    end else begin
      oe_o   <= drive;
      data_o <= drive ? sel : '0;
    end
  end

  // R4: the enable follows a high strobe sampled on the previous edge
  p_oe_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> $past(rc_i));

  // R4: the data port is quiet whenever the enable is low
  p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> (data_o == '0));

  // R10: nothing is enabled without a held result
  p_oe_valid_r10: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> $past(valid_i));

  // R6: in byte mode the lanes above the byte stay zero
  p_byte_hi_r6: assert property (@(posedge clk) disable iff (rst)
    oe_o && !$past(wide_i) |-> (data_o[RES_W-1:BYTE_W] == '0));
endmodule

// File: rtl/adc_sa_ctrl.sv
module adc_sa_ctrl
  import adc_sa_pkg::*;
#(
  parameter int CLK_NS  = 20,
  parameter int STS_NS  = 600,
  parameter int CONV_NS = 35000,
  parameter int HOLD_NS = 300,
  parameter int RES_W   = 12,
  parameter int BYTE_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rc_i,
  input  logic             wide_i,
  input  logic             addr_i,
  input  logic [RES_W-1:0] result_i,
  output logic             busy_o,
  output logic [RES_W-1:0] data_o,
  output logic             data_oe_o,
  output logic             overrun_o
);
  localparam int STS_CYC  = ns_to_cyc(STS_NS, CLK_NS);
  localparam int CONV_CYC = ns_to_cyc(CONV_NS, CLK_NS);
  localparam int HOLD_CYC = ns_to_cyc(HOLD_NS, CLK_NS);
  localparam int CNT_MAX  = (CONV_CYC > HOLD_CYC) ? CONV_CYC : HOLD_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic             fall;
  logic             valid;
  logic [RES_W-1:0] res_q;

  sa_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .rc_i   (rc_i),
    .fall_o (fall)
  );

  sa_conv_seq #(
    .RES_W    (RES_W),
    .STS_CYC  (STS_CYC),
    .CONV_CYC (CONV_CYC),
    .HOLD_CYC (HOLD_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .fall_i   (fall),
    .result_i (result_i),
    .busy_o   (busy_o),
    .ovr_o    (overrun_o),
    .valid_o  (valid),
    .res_o    (res_q)
  );

  sa_out_fmt #(
    .RES_W  (RES_W),
    .BYTE_W (BYTE_W)
  ) u_fmt (
    .clk     (clk),
    .rst     (rst),
    .rc_i    (rc_i),
    .wide_i  (wide_i),
    .addr_i  (addr_i),
    .valid_i (valid),
    .res_i   (res_q),
    .oe_o    (data_oe_o),
    .data_o  (data_o)
  );
endmodule

// File: tb/adc_sa_ctrl_tb_top.sv
module adc_sa_ctrl_tb_top;
  // Timing expectations from the requirements, at a 20 ns clock.
  localparam int T_STS  = 30;
  localparam int T_CONV = 1750;
  localparam int T_HOLD = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rc_i = 1'b1;
  logic        wide_i = 1'b1;
  logic        addr_i = 1'b0;
  logic [11:0] result_i = '0;
  logic        busy_o;
  logic [11:0] data_o;
  logic        data_oe_o;
  logic        overrun_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  adc_sa_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .rc_i      (rc_i),
    .wide_i    (wide_i),
    .addr_i    (addr_i),
    .result_i  (result_i),
    .busy_o    (busy_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .overrun_o (overrun_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [11:0] act,
                     input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R9
  task automatic t_reset();
    chk(busy_o == 1'b0, "R9 busy", {11'd0, busy_o}, 12'd0);
    chk(overrun_o == 1'b0, "R9 overrun", {11'd0, overrun_o}, 12'd0);
    chk(data_oe_o == 1'b0, "R9 oe", {11'd0, data_oe_o}, 12'd0);
    chk(data_o == 12'd0, "R9 data", data_o, 12'd0);
  endtask

  // R10: strobe high with no result yet
  task automatic t_no_result();
    rc_i = 1'b1;
    wait_n(5);
    chk(data_oe_o == 1'b0, "R10 no result oe", {11'd0, data_oe_o}, 12'd0);
  endtask

  // Low-pulse conversion; ovr_a/ovr_b > 0 inject stray falls (R8).
  task automatic run_conv(input logic [11:0] val, input int ovr_a, input int ovr_b);
    int drops = 0;
    result_i = ~val;
    rc_i = 1'b0;
    for (int k = 1; k <= T_CONV + T_HOLD + 1; k++) begin
      @(negedge clk);
      if (k == 15) rc_i = 1'b1;
      if (k == 1000) result_i = val;
      if (k == T_STS) chk(busy_o == 1'b0, "R1 busy early", {11'd0, busy_o}, 12'd0);
      if (k == T_STS + 1) chk(busy_o == 1'b1, "R1 busy rise", {11'd0, busy_o}, 12'd1);
      if (k > T_STS && k <= T_CONV + T_HOLD && !busy_o) drops++;
      if (k == T_CONV + 1) chk(data_oe_o == 1'b0, "R3 oe early", {11'd0, data_oe_o}, 12'd0);
      if (k == T_CONV + 2) begin
        chk(data_oe_o == 1'b1, "R4 oe on", {11'd0, data_oe_o}, 12'd1);
        chk(data_o == val, "R3 R5 result", data_o, val);
      end
      if (k == T_CONV + T_HOLD) chk(busy_o == 1'b1, "R3 busy hold", {11'd0, busy_o}, 12'd1);
      if (k == T_CONV + T_HOLD + 1) chk(busy_o == 1'b0, "R3 busy fall", {11'd0, busy_o}, 12'd0);
      if (ovr_a > 0) begin
        if (k == ovr_a) rc_i = 1'b0;
        if (k == ovr_a + 1) chk(overrun_o == 1'b1, "R8 flag", {11'd0, overrun_o}, 12'd1);
        if (k == ovr_a + 2) chk(overrun_o == 1'b0, "R8 pulse", {11'd0, overrun_o}, 12'd0);
        if (k == ovr_a + 3) rc_i = 1'b1;
      end
      if (ovr_b > 0) begin
        if (k == ovr_b) rc_i = 1'b0;
        if (k == ovr_b + 1) chk(overrun_o == 1'b1, "R8 flag hold", {11'd0, overrun_o}, 12'd1);
        if (k == ovr_b + 3) rc_i = 1'b1;
      end
    end
    chk(drops == 0, "R2 busy gaps", 12'(drops), 12'd0);
    wait_n(2);
    chk(data_o == val, "R8 result kept", data_o, val);
  endtask

  // R6, R7, R5 with held result 12'hA5C
  task automatic t_byte_modes();
    wide_i = 1'b0; addr_i = 1'b0;
    wait_n(1);
    chk(data_o == 12'h0A5, "R6 upper byte", data_o, 12'h0A5);
    addr_i = 1'b1;
    wait_n(1);
    chk(data_o == 12'h0C0, "R7 lower nibble", data_o, 12'h0C0);
    wide_i = 1'b1;
    wait_n(1);
    chk(data_o == 12'hA5C, "R5 full width", data_o, 12'hA5C);
    addr_i = 1'b0;
  endtask

  // R4, R10: high-pulse use, strobe low during conversion
  task automatic t_high_pulse();
    result_i = 12'h3F1;
    rc_i = 1'b0;
    for (int k = 1; k <= T_CONV + T_HOLD + 1; k++) begin
      @(negedge clk);
      if (k == T_CONV + 2) chk(data_oe_o == 1'b0, "R4 strobe low", {11'd0, data_oe_o}, 12'd0);
    end
    rc_i = 1'b1;
    wait_n(1);
    chk(data_oe_o == 1'b1 && data_o == 12'h3F1, "R4 high pulse read", data_o, 12'h3F1);
    wait_n(15);
    result_i = 12'h7E2;
    rc_i = 1'b0;
    wait_n(1);
    chk(data_oe_o == 1'b0 && data_o == 12'd0, "R10 start clears", data_o, 12'd0);
    wait_n(T_CONV + T_HOLD + 2);
    rc_i = 1'b1;
    wait_n(1);
    chk(data_o == 12'h7E2, "R4 second read", data_o, 12'h7E2);
    wait_n(15);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_no_result();
    run_conv(12'hA5C, 0, 0);
    t_byte_modes();
    t_high_pulse();
    run_conv(12'h123, 200, T_CONV + 5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule